// File: doc/BRIEF.md
# Pin Change Notification Controller

This block watches a set of asynchronous input pins and tells the processor when any selected pin has left the level it had when software last looked. Each pin has its own enable bit and its own weak pull-up request bit. Both kinds of bit are written through a small configuration port as two 16-bit words. The pull-up requests go out to the pad ring. A request is suppressed for any pin that is currently driven as a digital output.

The block keeps a snapshot of the synchronized pin levels. It refreshes that snapshot whenever software strobes a read of the input state or clears the interrupt flag. A clocked interrupt flag is set when a synchronized enabled pin differs from the snapshot. The flag stays set until software clears it. A second, purely combinational path compares the raw pins against the snapshot. That path produces a wakeup request which still works when every clock is stopped in sleep.

Top module: `pin_change_notifier`

## Requirements
- R1: After reset, `irq_o`, `wake_o` and every bit of `pullup_en_o` are 0, and all enable and pull-up bits are cleared.
- R2: A configuration write with `cfg_sel_i`=0 loads the enables of pins 0..15 from `cfg_wdata_i` bits 0..15. A write with `cfg_sel_i`=1 loads the enables of pins 16..NUM_PINS-1 from `cfg_wdata_i` bits 0 upward.
- R3: A level change on an enabled pin that is applied between clock edges sets `irq_o` after exactly SYNC_STAGES+1 rising edges (3 by default), and not earlier.
- R4: A pin whose enable bit is 0 never causes `irq_o` or `wake_o` to assert, whatever its level.
- R5: `wake_o` is 1, with no clock edge needed, whenever any enabled raw pin differs from the snapshot.
- R6: `irq_o` stays 1 until a cycle with `flag_clr_i`=1. A pin returning to its old level, or a read strobe, does not clear it. A clear takes effect at the next edge, even when the mismatch that set the flag still exists at that edge.
- R7: `state_o` shows the synchronized pin levels. A cycle with `state_rd_i` or `flag_clr_i` high copies those levels into the snapshot at the next edge.
- R8: A pin change that is still inside the synchronizer when a clear is taken is not lost. The snapshot keeps the old level for that pin, and `irq_o` sets again once the change is synchronized.
- R9: Pull-up bits are written with `cfg_sel_i`=2 (pins 0..15) and `cfg_sel_i`=3 (pins 16 up), in the same bit layout as R2. `pullup_en_o[k]` equals the stored bit AND NOT `pin_is_out_i[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| pin_is_out_i | input | NUM_PINS | 1 where the pin is configured as a digital output |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Word select: 0/1 enable low/high, 2/3 pull-up low/high |
| cfg_wdata_i | input | 16 | Configuration write data |
| state_rd_i | input | 1 | Software read of the input state (refreshes snapshot) |
| state_o | output | NUM_PINS | Synchronized pin levels |
| flag_clr_i | input | 1 | Write-one-to-clear of the interrupt flag (refreshes snapshot) |
| irq_o | output | 1 | Sticky interrupt flag |
| wake_o | output | 1 | Combinational wakeup request |
| pullup_en_o | output | NUM_PINS | Weak pull-up enable to the pads |

## Verification
The bench times the flag to the exact edge. A synchronizer that is one stage short or one stage long would raise it a cycle early or late. It clears the flag in the same edge that a second pin change is still travelling through the synchronizer. A design that snapshots the raw pins, or lets clear erase pending changes, would drop that event for good. It drives high levels on pins in the upper enable word and on disabled pins. Wrong word decoding or missing masking would then raise the flag or the wakeup where none is due. It also checks that pull-ups vanish on output pins and that a read strobe leaves the flag set.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
   localparam int REG_W = 16;

   typedef enum logic [1:0] {
      SEL_EN_LO = 2'd0,
      SEL_EN_HI = 2'd1,
      SEL_PU_LO = 2'd2,
      SEL_PU_HI = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/pcn_sync.sv
module pcn_sync #(
   parameter int WIDTH  = 31,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcn_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcn_cfg_regs.sv
module pcn_cfg_regs
   import pcn_pkg::*;
#(
   parameter int NUM_PINS = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [1:0]          sel_i,
   input  logic [REG_W-1:0]    wdata_i,
   output logic [NUM_PINS-1:0] en_o,
   output logic [NUM_PINS-1:0] pu_o
);
   localparam int WORDS = (NUM_PINS + REG_W - 1) / REG_W;

   if (WORDS > 2) begin : g_bad_words
      $error("pcn_cfg_regs: NUM_PINS exceeds two configuration words");
   end

   cfg_sel_e sel;
   assign sel = cfg_sel_e'(sel_i);

   logic [NUM_PINS-1:0] en_q, pu_q;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_bit
      localparam int       OFS    = g % REG_W;
      localparam cfg_sel_e EN_SEL = (g < REG_W) ? SEL_EN_LO : SEL_EN_HI;
      localparam cfg_sel_e PU_SEL = (g < REG_W) ? SEL_PU_LO : SEL_PU_HI;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[g] <= 1'b0;
            pu_q[g] <= 1'b0;
         end else if (we_i) begin
            if (sel == EN_SEL) en_q[g] <= wdata_i[OFS];
            if (sel == PU_SEL) pu_q[g] <= wdata_i[OFS];
         end
      end
   end

   assign en_o = en_q;
   assign pu_o = pu_q;

   // R2
   en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(en_q));
endmodule

// File: rtl/pcn_detect.sv
module pcn_detect #(
   parameter int NUM_PINS = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_raw_i,
   input  logic [NUM_PINS-1:0] pin_sync_i,
   input  logic [NUM_PINS-1:0] en_i,
   input  logic                rd_i,
   input  logic                clr_i,
   output logic                irq_o,
   output logic                wake_o
);
   logic [NUM_PINS-1:0] snap_q;
   logic                flag_q;
   logic                refresh;
   logic                mis_any;

   assign refresh = rd_i | clr_i;
   assign mis_any = |((pin_sync_i ^ snap_q) & en_i);

   // clock-free path: usable while clocks are gated
   assign wake_o = |((pin_raw_i ^ snap_q) & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q <= '0;
      else if (refresh) snap_q <= pin_sync_i;
   end

   // clear wins: the same edge re-bases the snapshot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (clr_i)   flag_q <= 1'b0;
      else if (mis_any) flag_q <= 1'b1;
   end

   assign irq_o = flag_q;

   // R3
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(mis_any));
   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flag_q);
   // R7
   snap_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |=> (snap_q == $past(pin_sync_i)));
   // R4
   wake_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i == '0) |-> !wake_o);
endmodule

// File: rtl/pin_change_notifier.sv
module pin_change_notifier
   import pcn_pkg::*;
#(
   parameter int NUM_PINS    = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [NUM_PINS-1:0] pin_is_out_i,
   input  logic                cfg_we_i,
   input  logic [1:0]          cfg_sel_i,
   input  logic [REG_W-1:0]    cfg_wdata_i,
   input  logic                state_rd_i,
   output logic [NUM_PINS-1:0] state_o,
   input  logic                flag_clr_i,
   output logic                irq_o,
   output logic                wake_o,
   output logic [NUM_PINS-1:0] pullup_en_o
);
   if (NUM_PINS < 1 || NUM_PINS > 2*REG_W - 1) begin : g_bad_pins
      $error("pin_change_notifier: NUM_PINS must be 1..31");
   end

   logic [NUM_PINS-1:0] pin_sync, en, pu;

   pcn_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   pcn_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_wdata_i),
      .en_o    (en),
      .pu_o    (pu)
   );

   pcn_detect #(.NUM_PINS(NUM_PINS)) u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_raw_i  (pin_i),
      .pin_sync_i (pin_sync),
      .en_i       (en),
      .rd_i       (state_rd_i),
      .clr_i      (flag_clr_i),
      .irq_o      (irq_o),
      .wake_o     (wake_o)
   );

   assign state_o     = pin_sync;
   assign pullup_en_o = pu & ~pin_is_out_i;

   // R9
   pullup_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pullup_en_o & pin_is_out_i) == '0);
endmodule

// File: tb/pin_change_notifier_bench.sv
module pin_change_notifier_bench;
   localparam int N = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_i = '0, pin_is_out_i = '0;
   logic          cfg_we_i = 1'b0;
   logic [1:0]    cfg_sel_i = '0;
   logic [15:0]   cfg_wdata_i = '0;
   logic          state_rd_i = 1'b0, flag_clr_i = 1'b0;
   logic [N-1:0]  state_o, pullup_en_o;
   logic          irq_o, wake_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pin_change_notifier u_pin_change_notifier (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_is_out_i(pin_is_out_i),
      .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
      .state_rd_i(state_rd_i), .state_o(state_o), .flag_clr_i(flag_clr_i),
      .irq_o(irq_o), .wake_o(wake_o), .pullup_en_o(pullup_en_o));

   typedef struct packed {
      logic [N-1:0] pins;
      logic [N-1:0] en;
      logic         exp;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{31'h0000_0001, 31'h0000_0001, 1'b1},
      '{31'h0000_0001, 31'h0000_0002, 1'b0},
      '{31'h4000_0000, 31'h4000_0000, 1'b1},
      '{31'h0001_0000, 31'h7FFF_0000, 1'b1},
      '{31'h7FFF_FFFF, 31'h0000_0000, 1'b0},
      '{31'h0000_FFFF, 31'h7FFF_0000, 1'b0},
      '{31'h0000_8000, 31'h7FFF_8000, 1'b1}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(logic [1:0] sel, logic [15:0] data);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic set_enables(logic [N-1:0] en);
      cfg_write(2'd0, en[15:0]);
      cfg_write(2'd1, {1'b0, en[N-1:16]});
   endtask

   task automatic pulse_clr();
      @(negedge clk); flag_clr_i = 1'b1;
      @(negedge clk); flag_clr_i = 1'b0;
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // re-base: pins low, enables set, snapshot and flag cleared
   task automatic rebase(logic [N-1:0] en);
      @(negedge clk); pin_i = '0;
      set_enables(en);
      edges(3);
      pulse_clr();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq after reset", {31'b0, irq_o}, 32'd0);
      check("R1 wake after reset", {31'b0, wake_o}, 32'd0);
      check("R1 pullups after reset", {1'b0, pullup_en_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5
      foreach (VECS[i]) begin
         rebase(VECS[i].en);
         pin_i = VECS[i].pins;
         #1;
         check($sformatf("R5 wake vec%0d", i), {31'b0, wake_o}, {31'b0, VECS[i].exp});
         edges(3);
         check($sformatf("R2/R4 irq vec%0d", i), {31'b0, irq_o}, {31'b0, VECS[i].exp});
      end

      // R3 exact latency
      rebase(31'h0000_0004);
      pin_i = 31'h0000_0004;
      edges(2);
      check("R3 irq not before third edge", {31'b0, irq_o}, 32'd0);
      edges(1);
      check("R3 irq at third edge", {31'b0, irq_o}, 32'd1);

      // R7 state readback
      check("R7 state_o shows synced pins", {1'b0, state_o}, 32'h0000_0004);

      // R6 sticky: pin returns, read strobe, then clear
      pin_i = '0;
      edges(5);
      check("R6 irq holds after pin returns", {31'b0, irq_o}, 32'd1);
      @(negedge clk); state_rd_i = 1'b1;
      @(negedge clk); state_rd_i = 1'b0;
      check("R6 read strobe keeps irq", {31'b0, irq_o}, 32'd1);
      pulse_clr();
      check("R6 clear drops irq", {31'b0, irq_o}, 32'd0);

      // R7 read refresh removes wake; R6 clear wins over standing mismatch
      pin_i = 31'h0000_0004;
      edges(4);
      check("R7 wake before read", {31'b0, wake_o}, 32'd1);
      @(negedge clk); state_rd_i = 1'b1;
      @(negedge clk); state_rd_i = 1'b0;
      #1;
      check("R7 wake after read refresh", {31'b0, wake_o}, 32'd0);
      pulse_clr();
      edges(4);
      check("R6 irq stays clear after clear", {31'b0, irq_o}, 32'd0);

      // R8 change inside synchronizer during clear
      rebase(31'h0000_0003);
      pin_i = 31'h0000_0001;
      edges(3);
      check("R8 irq from pin0", {31'b0, irq_o}, 32'd1);
      @(negedge clk);
      pin_i = 31'h0000_0003; flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      check("R8 irq cleared", {31'b0, irq_o}, 32'd0);
      check("R8 wake kept by pending pin1", {31'b0, wake_o}, 32'd1);
      edges(2);
      check("R8 irq sets again for pin1", {31'b0, irq_o}, 32'd1);

      // R9 pull-ups
      cfg_write(2'd2, 16'hFFFF);
      cfg_write(2'd3, 16'h7FFF);
      #1;
      check("R9 all pull-ups", {1'b0, pullup_en_o}, 32'h7FFF_FFFF);
      pin_is_out_i = 31'h0001_00F0;
      #1;
      check("R9 output pins masked", {1'b0, pullup_en_o}, 32'h7FFE_FF0F);
      cfg_write(2'd3, 16'h0000);
      #1;
      check("R9 high word cleared", {1'b0, pullup_en_o}, 32'h0000_FF0F);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule